// File: doc/BRIEF.md
# Digit-Serial Integer Multiply Unit

This block is the iterative multiplier in the ALU of a 32-bit processor. It builds the product of two 32-bit operands with one 32x4-bit partial-product multiplier. Each step retires four bits of the multiplier operand, so eight steps cover the full word. Only the low 32 bits of the product are returned. That low word is the same for signed and unsigned operands, so there is no signedness control. A second operand source takes a 16-bit immediate and sign-extends it, which serves the multiply-by-immediate instruction.

A request is a one-cycle `start` strobe with the operands held valid in that cycle. The unit is occupied for eleven issue cycles: one to capture the operands, eight multiply steps and two cycles of write-back staging. The result then follows two cycles later. `busy` covers the whole window, and `result_valid` pulses for one cycle when the product is ready. A build parameter can mark the multiplier as absent. In that build a request raises a one-cycle illegal-instruction exception and no result is produced.

Top module: `nib_mul_unit`

## Requirements
- R1: After reset, `busy`, `result_valid` and `illegal_exc` are 0 and `result` is 0.
- R2: With `use_imm`=0, `result` equals the low 32 bits of `op_a` times `op_b`, for any bit patterns of the operands. Two's-complement negatives give the same low word as their unsigned patterns.
- R3: With `use_imm`=1, the second operand is `imm` sign-extended from bit 15 to 32 bits, and `op_b` is not used.
- R4: A request is accepted on a rising edge where `start`=1 and `busy`=0. `result_valid` is 1 for exactly one cycle, beginning after the 13th rising edge following the accepting edge. That count is 11 issue cycles plus 2 cycles of result latency.
- R5: `busy` is 1 after each of the 1st to 12th rising edges following acceptance. It is 0 in the cycle where `result_valid` is 1.
- R6: A `start` while `busy`=1 is ignored. The result and the completion timing are those of the request already in progress, whatever operands are shown with the ignored strobe.
- R7: `result` holds its value from one completion until the next completion.
- R8: With `HW_PRESENT`=0, a `start` makes `illegal_exc` 1 for exactly the one cycle after the edge that samples it. `busy` and `result_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, one cycle |
| use_imm | input | 1 | 1 selects the sign-extended immediate as the second operand |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Second operand for the register form |
| imm | input | 16 | Immediate for the immediate form |
| busy | output | 1 | Unit occupied by a request |
| result_valid | output | 1 | One-cycle pulse, result ready |
| result | output | 32 | Low 32 bits of the product, held until the next completion |
| illegal_exc | output | 1 | One-cycle exception pulse when the multiplier is absent |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a computation with different operands. If the unit took it, the accumulator or the sequencer count would be corrupted without any visible sign until the end. The stimulus injects such a strobe, with fresh random operands, at a chosen step of a number of requests. It then checks that both the product and the 13-edge completion timing belong to the first request. Operand values with the top nibble set and all-ones patterns exercise the carries into the last partial product. The negative immediate 0x8000 exercises the sign-extension edge.

// File: rtl/nib_mul_pkg.sv
package nib_mul_pkg;
    localparam int XLEN       = 32;
    localparam int DIGIT_W    = 4;
    localparam int IMM_W      = 16;
    localparam int ISSUE_CYC  = 11;
    localparam int RESULT_LAT = 2;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction
endpackage

// File: rtl/nib_mul_pp.sv
module nib_mul_pp #(
    parameter int WIDTH = nib_mul_pkg::XLEN,
    parameter int DIGIT = nib_mul_pkg::DIGIT_W
) (
    input  logic [WIDTH-1:0] mcand,
    input  logic [DIGIT-1:0] digit,
    output logic [WIDTH-1:0] prod
);
    logic [WIDTH-1:0] term [DIGIT];

    for (genvar i = 0; i < DIGIT; i++) begin : g_term
        assign term[i] = digit[i] ? (mcand << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < DIGIT; i++) begin
            prod = prod + term[i];
        end
    end
endmodule

// File: rtl/nib_mul_seq.sv
module nib_mul_seq #(
    parameter int  STEPS      = 8,
    parameter int  TOTAL      = nib_mul_pkg::ISSUE_CYC + nib_mul_pkg::RESULT_LAT,
    parameter bit  HW_PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic step_en,
    output logic finish,
    output logic busy,
    output logic valid,
    output logic exc
);
    localparam int CNT_W = $clog2(TOTAL);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             exc;
    } seq_t;

    seq_t s_d, s_q;

    assign accept  = start && !s_q.busy && HW_PRESENT;
    assign step_en = s_q.busy && (s_q.cnt < CNT_W'(STEPS));
    assign finish  = s_q.busy && (s_q.cnt == CNT_W'(TOTAL - 1));
    assign busy    = s_q.busy;
    assign valid   = s_q.valid;
    assign exc     = s_q.exc;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.exc   = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                if (HW_PRESENT) begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = '0;
                end else begin
                    s_d.exc = 1'b1;
                end
            end
        end else if (finish) begin
            s_d.busy  = 1'b0;
            s_d.valid = 1'b1;
            s_d.cnt   = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a completion pulse only ends a busy window and lasts one cycle
    assert_valid_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(busy) && !$past(valid)));
    // R5: busy drops only into a completion
    assert_busy_ends_in_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> valid);
    // R6: a strobe during busy does not shorten or restart the window
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> (busy && !valid));
    // R8: an exception needs a strobe on the previous edge and never meets a result
    assert_exc_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> ($past(start) && !valid && !busy));
endmodule

// File: rtl/nib_mul_unit.sv
module nib_mul_unit #(
    parameter int WIDTH      = nib_mul_pkg::XLEN,
    parameter int DIGIT      = nib_mul_pkg::DIGIT_W,
    parameter int IMM_BITS   = nib_mul_pkg::IMM_W,
    parameter int ISSUE      = nib_mul_pkg::ISSUE_CYC,
    parameter int LATENCY    = nib_mul_pkg::RESULT_LAT,
    parameter bit HW_PRESENT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                use_imm,
    input  logic [WIDTH-1:0]    op_a,
    input  logic [WIDTH-1:0]    op_b,
    input  logic [IMM_BITS-1:0] imm,
    output logic                busy,
    output logic                result_valid,
    output logic [WIDTH-1:0]    result,
    output logic                illegal_exc
);
    localparam int STEPS = WIDTH / DIGIT;
    localparam int TOTAL = ISSUE + LATENCY;

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] mcand;
        logic [WIDTH-1:0] mplier;
        logic [WIDTH-1:0] res;
    } dp_t;

    dp_t              dp_d, dp_q;
    logic             accept, step_en, finish;
    logic [WIDTH-1:0] pp;
    logic [WIDTH-1:0] b_eff;

    assign b_eff = use_imm ? {{(WIDTH-IMM_BITS){imm[IMM_BITS-1]}}, imm} : op_b;

    nib_mul_seq #(.STEPS(STEPS), .TOTAL(TOTAL), .HW_PRESENT(HW_PRESENT)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .step_en(step_en), .finish(finish),
        .busy(busy), .valid(result_valid), .exc(illegal_exc)
    );

    nib_mul_pp #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_pp (
        .mcand(dp_q.mcand), .digit(dp_q.mplier[DIGIT-1:0]), .prod(pp)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.acc    = '0;
            dp_d.mcand  = op_a;
            dp_d.mplier = b_eff;
        end else if (step_en) begin
            dp_d.acc    = dp_q.acc + pp;
            dp_d.mcand  = dp_q.mcand << DIGIT;
            dp_d.mplier = dp_q.mplier >> DIGIT;
        end
        if (finish) dp_d.res = dp_q.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign result = dp_q.res;

    // R7: the result register changes only together with a completion pulse
    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    if (!HW_PRESENT) begin : g_absent
        // R8: an absent multiplier never reports a result nor goes busy
        assert_absent_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !result_valid && !busy);
    end
endmodule

// File: tb/nib_mul_unit_tb.sv
module nib_mul_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, use_imm = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [15:0] imm = '0;
    logic        busy, result_valid, illegal_exc;
    logic [31:0] result;

    logic        start2 = 1'b0;
    logic        busy2, valid2, exc2;
    logic [31:0] result2;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nib_mul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .use_imm(use_imm),
        .op_a(op_a), .op_b(op_b), .imm(imm), .busy(busy),
        .result_valid(result_valid), .result(result), .illegal_exc(illegal_exc)
    );

    nib_mul_unit #(.HW_PRESENT(1'b0)) u_dut_absent (
        .clk(clk), .rst_n(rst_n), .start(start2), .use_imm(1'b0),
        .op_a(32'h1234_5678), .op_b(32'h9), .imm(16'h0), .busy(busy2),
        .result_valid(valid2), .result(result2), .illegal_exc(exc2)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic ui, input logic [15:0] im);
        logic [63:0] p;
        logic [31:0] be;
        be = ui ? {{16{im[15]}}, im} : b;
        p  = {32'h0, a} * {32'h0, be};
        return p[31:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic ui,
                          input logic [15:0] im, input int inject_at);
        logic [31:0] exp;
        logic        ok_busy;
        exp = model(a, b, ui, im);
        @(negedge clk);
        op_a = a; op_b = b; use_imm = ui; imm = im; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        ok_busy = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (!busy || result_valid) ok_busy = 1'b0;
            start = 1'b0;
            if (k == inject_at) begin
                // R6: foreign strobe with fresh operands during the busy window
                op_a = $urandom; op_b = $urandom; imm = 16'($urandom);
                use_imm = 1'($urandom); start = 1'b1;
            end
        end
        chk("R5 busy window", {31'h0, ok_busy}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R4 valid at edge 13", {30'h0, result_valid, busy}, 32'h2);
        chk(inject_at > 0 ? "R6 product after ignored start" :
            (ui ? "R3 immediate product" : "R2 product"), result, exp);
        @(posedge clk);
        @(negedge clk);
        chk("R4 single-cycle valid", {31'h0, result_valid}, 32'h0);
        chk("R7 result held", result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset flags", {29'h0, busy, result_valid, illegal_exc}, 32'h0);
        chk("R1 reset result", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'h0, busy, result_valid, illegal_exc}, 32'h0);

        run_op(32'h0, 32'hFFFF_FFFF, 1'b0, 16'h0, 0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 16'h0, 0);
        run_op(32'hF000_000F, 32'h1000_0001, 1'b0, 16'h0, 0);
        run_op(32'hFFFF_FFFD, 32'h0000_0007, 1'b0, 16'h0, 0);
        run_op(32'h0001_2345, 32'hDEAD_BEEF, 1'b1, 16'h8000, 0);
        run_op(32'h0000_0003, 32'h0, 1'b1, 16'h7FFF, 0);
        run_op(32'h8765_4321, 32'h5555_5555, 1'b1, 16'hFFFF, 0);
        run_op(32'hABCD_EF01, 32'h1357_9BDF, 1'b0, 16'h0, 1);
        run_op(32'h1111_1111, 32'hF0F0_F0F0, 1'b0, 16'h0, 12);

        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b;
            logic        ui;
            logic [15:0] im;
            a = $urandom; b = $urandom; ui = 1'($urandom); im = 16'($urandom);
            run_op(a, b, ui, im, (i % 5 == 0) ? int'($urandom_range(12, 1)) : 0);
        end

        // R8: absent multiplier build
        @(negedge clk);
        start2 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start2 = 1'b0;
        chk("R8 exception pulse", {29'h0, exc2, busy2, valid2}, 32'h4);
        begin
            logic seen;
            seen = 1'b0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (exc2 || busy2 || valid2) seen = 1'b1;
            end
            chk("R8 no result, one-cycle exception", {31'h0, seen}, 32'h0);
        end
        chk("R8 result untouched", result2, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule